// File: doc/BRIEF.md
# Limit-Compare Interval Timer

The block is a programmable interval timer. A tick strobe, arriving from an external rate source, drives a prescaler. When the prescaler runs down, the count register advances by an increment. The increment is 1 in normal mode and 10 in fine mode, and the count wraps at the register width. After each advance, the new count is compared with a limit register. A match raises a sticky limit flag. If the limit flag is still set from an earlier match, the match raises a second sticky flag, the lost-tick flag, which marks an overrun.

A control word sets the behaviour. It selects the prescale rate and turns prescaling on or off. It also chooses between normal and fine increments, makes the count return to zero on a match, and enables the interrupt request. Writing the control word with its flag-clear bit set clears both flags and the interrupt-active flip-flop.

An interrupt request is raised on a match only when no earlier interrupt is still marked active. Acknowledging the request drops it and marks the interrupt active. The register write port is a plain strobe with a select code. It has no back-pressure: every write is taken in the cycle it is presented. The tick input and the acknowledge input are single-cycle strobes that the block always accepts.

Top module: `lt_interval_timer`

## Requirements
- R1: When control bit 3 (prescale enable) is set with rate field bits 2:0 = r, the count advances once for every 2^r tick strobes. The ticks are counted from the last control write or from the last advance. When bit 3 is clear, every tick strobe advances the count.
- R2: Each advance adds 10 when control bit 4 (fine mode) is set and 1 otherwise. The result wraps modulo 2^16. Without a write or an advance, the count holds.
- R3: An advance whose result equals the limit register (written with select 1) sets the limit flag.
- R4: A matching advance while the limit flag is already set sets the lost-tick flag and leaves the limit flag set. Both flags are sticky.
- R5: A control write with bit 7 (flag clear) set clears the limit flag and the lost-tick flag. Bit 7 is not stored.
- R6: When control bit 5 (auto-clear) is set, a matching advance leaves the count at zero.
- R7: A match raises the interrupt request only if control bit 6 (interrupt enable) is set and the interrupt-active flip-flop is clear. The acknowledge input drops the request and sets the active flip-flop. A control write with bit 7 set clears the active flip-flop.
- R8: A count write (select 2) in the same cycle as an advance wins. The count takes the written value, and that advance produces no limit event.
- R9: A control write (select 0) reloads the prescaler for the newly written rate, and a tick in that same cycle is ignored.
- R10: After reset, the count is 0, the limit register is all ones, all flags and the request are low, and the control word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 limit, 2 count |
| wr_data | input | 16 | Write data; control uses bits 7:0 |
| tick | input | 1 | Rate tick strobe |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq_req | output | 1 | Interrupt request |
| limit_flag | output | 1 | Sticky limit-reached flag |
| lost_flag | output | 1 | Sticky lost-tick (overrun) flag |
| count_o | output | 16 | Current count register |

## Verification
A wrong prescaler value shows at the ports as a count that steps on the wrong tick. That error becomes visible within one prescale period, at most 128 ticks. A wrong adder or a wrong compare shows on `count_o` or on the flags in the cycle right after the advance. A mis-set interrupt-active flip-flop shows only at the next match: either a request appears while an earlier interrupt is still active, or a request that should appear is missing. The bench therefore runs a second match after every acknowledge and after every clear.

// File: rtl/lt_timer_pkg.sv
package lt_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_COUNT = 2'd2
  } wr_sel_e;

  // control byte layout, MSB first
  typedef struct packed {
    logic       clr_flags;
    logic       irq_en;
    logic       auto_clr;
    logic       fine;
    logic       pre_en;
    logic [2:0] rate;
  } ctrl_t;

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int RATE_W = 3,
  parameter int PRE_W  = 2**RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reload,
  input  logic              pre_en,
  input  logic [RATE_W-1:0] rate,
  output logic              adv
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] scale;

  always_comb begin
    scale = pre_en ? (PRE_W'(1) << rate) : PRE_W'(1);
    adv   = tick && !reload && (pre_q == PRE_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_W'(1);
    end else if (reload) begin
      pre_q <= scale;
    end else if (tick) begin
      if (pre_q == PRE_W'(1)) pre_q <= scale;
      else                    pre_q <= pre_q - PRE_W'(1);
    end
  end

  // R1
  pre_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q != '0);

  // R9
  reload_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> !adv);

endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W    = 16,
  parameter int FINE_INC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             fine,
  input  logic             auto_clr,
  input  logic [CNT_W-1:0] limit,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] sum;
  logic             step;

  always_comb begin
    inc  = fine ? CNT_W'(FINE_INC) : CNT_W'(1);
    sum  = count + inc;
    step = adv && !wr_cnt;
    hit  = step && (sum == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (wr_cnt)           count <= wr_data;
    else if (step)             count <= (hit && auto_clr) ? '0 : sum;
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr_cnt) |=> $stable(count));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (count == $past(wr_data)));

endmodule

// File: rtl/lt_events.sv
module lt_events (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  input  logic ack,
  output logic limit_flag,
  output logic lost_flag,
  output logic irq_req
);

  logic active_q;
  logic lim_base, lost_base;

  always_comb begin
    lim_base  = clr ? 1'b0 : limit_flag;
    lost_base = clr ? 1'b0 : lost_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_flag <= 1'b0;
      lost_flag  <= 1'b0;
      active_q   <= 1'b0;
      irq_req    <= 1'b0;
    end else begin
      limit_flag <= lim_base | hit;
      lost_flag  <= lost_base | (hit & lim_base);
      if (ack)      active_q <= 1'b1;
      else if (clr) active_q <= 1'b0;
      if (ack)                               irq_req <= 1'b0;
      else if (hit && irq_en && !active_q)   irq_req <= 1'b1;
    end
  end

  // R4
  lost_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_flag) |-> $past(limit_flag));

  // R7
  irq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_req);

  // R7
  irq_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(!active_q) && $past(irq_en)));

endmodule

// File: rtl/lt_interval_timer.sv
module lt_interval_timer #(
  parameter int CNT_W    = 16,
  parameter int RATE_W   = 3,
  parameter int FINE_INC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic             limit_flag,
  output logic             lost_flag,
  output logic [CNT_W-1:0] count_o
);
  import lt_timer_pkg::*;

  localparam int PRE_W  = 2**RATE_W;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q, ctrl_in;
  logic [CNT_W-1:0] limit_q;
  logic             wr_ctrl, wr_lim, wr_cnt;
  logic             adv, hit;

  always_comb begin
    ctrl_in = ctrl_t'(wr_data[CTRL_W-1:0]);
    wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    wr_lim  = wr_en && (wr_sel == SEL_LIMIT);
    wr_cnt  = wr_en && (wr_sel == SEL_COUNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      limit_q <= '1;
    end else begin
      if (wr_ctrl) begin
        ctrl_q           <= ctrl_in;
        ctrl_q.clr_flags <= 1'b0;
      end
      if (wr_lim) limit_q <= wr_data;
    end
  end

  lt_prescaler #(.RATE_W(RATE_W), .PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .reload (wr_ctrl),
    .pre_en (wr_ctrl ? ctrl_in.pre_en : ctrl_q.pre_en),
    .rate   (wr_ctrl ? ctrl_in.rate   : ctrl_q.rate),
    .adv    (adv)
  );

  lt_counter #(.CNT_W(CNT_W), .FINE_INC(FINE_INC)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .fine     (ctrl_q.fine),
    .auto_clr (ctrl_q.auto_clr),
    .limit    (limit_q),
    .wr_cnt   (wr_cnt),
    .wr_data  (wr_data),
    .count    (count_o),
    .hit      (hit)
  );

  lt_events u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .clr        (wr_ctrl && ctrl_in.clr_flags),
    .irq_en     (ctrl_q.irq_en),
    .ack        (irq_ack),
    .limit_flag (limit_flag),
    .lost_flag  (lost_flag),
    .irq_req    (irq_req)
  );

  // R5
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_in.clr_flags) |=> (!limit_flag && !lost_flag));

  // R6
  auto_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl_q.auto_clr) |=> (count_o == '0));

endmodule

// File: tb/lt_interval_timer_tb.sv
module lt_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        tick = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req, limit_flag, lost_flag;
  logic [15:0] count_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lt_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .irq_ack(irq_ack),
    .irq_req(irq_req), .limit_flag(limit_flag), .lost_flag(lost_flag),
    .count_o(count_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 count", count_o, 0);
    check("R10 limit_flag", limit_flag, 0);
    check("R10 lost_flag", lost_flag, 0);
    check("R10 irq", irq_req, 0);

    // R1 prescale sweep, rates 0..3
    wr(2'd1, 16'hFFFF);
    for (int r = 0; r < 4; r++) begin
      wr(2'd2, 16'd0);
      wr(2'd0, 16'(8 | r));
      for (int k = 1; k <= 2 * (1 << r) + 1; k++) begin
        ticks(1);
        check($sformatf("R1 rate%0d tick%0d", r, k), count_o, k / (1 << r));
      end
    end
    // R1 prescale disabled: rate field ignored
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0003);
    for (int k = 1; k <= 4; k++) begin
      ticks(1);
      check("R1 nopre", count_o, k);
    end

    // R2 fine increments and wrap
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0010);
    for (int k = 1; k <= 5; k++) begin
      ticks(1);
      check("R2 fine", count_o, 10 * k);
    end
    wr(2'd2, 16'hFFFB);
    ticks(1);
    check("R2 wrap", count_o, 5);
    repeat (3) @(negedge clk);
    check("R2 hold", count_o, 5);

    // R3 / R4 limit and lost
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd0);
    ticks(4);
    check("R3 before", limit_flag, 0);
    ticks(1);
    check("R3 flag", limit_flag, 1);
    check("R3 count", count_o, 5);
    check("R4 no lost yet", lost_flag, 0);
    wr(2'd2, 16'd4);
    ticks(1);
    check("R4 lost", lost_flag, 1);
    check("R4 limit kept", limit_flag, 1);
    ticks(1);
    check("R4 sticky", lost_flag, 1);

    // R5 clear
    wr(2'd0, 16'h0080);
    check("R5 limit cleared", limit_flag, 0);
    check("R5 lost cleared", lost_flag, 0);

    // R6 auto clear
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd0);
    ticks(3);
    check("R6 zero", count_o, 0);
    check("R6 flag", limit_flag, 1);
    ticks(3);
    check("R6 zero again", count_o, 0);
    check("R6 lost", lost_flag, 1);

    // R7 interrupt handshake
    wr(2'd0, 16'h0080);
    wr(2'd0, 16'h0060);
    ticks(2);
    check("R7 no irq yet", irq_req, 0);
    ticks(1);
    check("R7 irq", irq_req, 1);
    ack();
    check("R7 ack drop", irq_req, 0);
    ticks(3);
    check("R7 active blocks", irq_req, 0);
    check("R7 lost", lost_flag, 1);
    wr(2'd0, 16'h00E0);
    check("R7 clr flags", limit_flag, 0);
    ticks(3);
    check("R7 irq after clear", irq_req, 1);
    ack();
    wr(2'd0, 16'h00A0);
    ticks(3);
    check("R7 disabled", irq_req, 0);
    check("R7 disabled flag", limit_flag, 1);

    // R8 count write beats advance
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'h1235);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h1234;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R8 write wins", count_o, 16'h1234);
    check("R8 no event", limit_flag, 0);
    ticks(1);
    check("R8 next advance", count_o, 16'h1235);
    check("R8 match", limit_flag, 1);

    // R9 control write reloads prescaler, same-cycle tick ignored
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h008A);
    ticks(3);
    check("R9 partial", count_o, 0);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h000A;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R9 tick ignored", count_o, 0);
    ticks(3);
    check("R9 reloaded", count_o, 0);
    ticks(1);
    check("R9 advance", count_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule